// File: doc/BRIEF.md
# Two-Stage I2C SCL Clock Generator

This block derives the serial clock timing of an I2C master from the peripheral clock. A first prescaler divides the clock by (A+1), a second divides the result by (B+1), and each resulting tick advances a 22-step phase sequencer. The first eleven steps drive SCL low and the last eleven release it. A bus period therefore spans 22·(A+1)·(B+1) clock cycles. A is 2 bits wide and B is 6 bits wide, and software picks both values.

The bit engine gets single-cycle strobes at fixed points of each period. One strobe marks the point where SDA may change, in the middle of the low half. Another marks the point where SDA is sampled, in the middle of the high half, and the START and STOP timing points fall on that same point. While SCL is released but still reads back low, the sequencer stalls, so a target can stretch the clock. A hold request that meets a byte boundary freezes the generator with SCL driven low until the request is withdrawn. Divisor changes wait for the next period boundary.

Top module: `i2c_scl_gen`

## Requirements
- R1: After reset, with `enable` low, `scl_low` is 0 and every strobe output is 0.
- R2: With `enable` high and the line never held low by another device, SCL is driven low for 11·U cycles and released for 11·U cycles, where U = (A+1)·(B+1). The line goes low in the first cycle that `enable` is high, and again every 22·U cycles after that.
- R3: A is taken from the 2-bit `div_a` and B from the 6-bit `div_b`. The full range up to A=3, B=63 gives a period of 5632 cycles.
- R4: Take N as the cycle in which the period starts. `sda_chg` pulses for one cycle at N+6U−1, and `sda_smp` pulses for one cycle at N+17U−1.
- R5: `cond` = 1 requests START and `cond` = 2 requests STOP. `start_pt` or `stop_pt` pulses in the same cycle as `sda_smp`, and neither pulses when `cond` = 0.
- R6: When SCL is released and `scl_in` reads 0, the sequencer and both prescalers stall, and every later event moves by the number of stalled cycles. A low `scl_in` during the low half has no effect.
- R7: At a period boundary, if `hold_req` and `last_bit` are both 1, `scl_low` stays 1 with no strobes until `hold_req` drops. A fresh period then starts in the cycle after the one in which `hold_req` is first seen low. `hold_req` alone, with `last_bit` = 0, has no effect.
- R8: The divisors are captured only while the block is disabled, at a period boundary, or on leaving hold. A change in mid-period alters only the periods that follow.
- R9: When `enable` is low, `scl_low` is 0 and no strobe pulses. Raising `enable` again starts a new period from its first low step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Master mode enable |
| div_a | input | 2 | First prescaler divisor A |
| div_b | input | 6 | Second prescaler divisor B |
| scl_in | input | 1 | Sensed SCL line level |
| hold_req | input | 1 | Request to hold SCL low at a byte boundary |
| last_bit | input | 1 | The current period carries the final bit of a byte |
| cond | input | 2 | Condition for this period: 0 none, 1 START, 2 STOP |
| scl_low | output | 1 | 1 drives SCL low, 0 releases it |
| sda_chg | output | 1 | Strobe: SDA may change now |
| sda_smp | output | 1 | Strobe: sample SDA now |
| start_pt | output | 1 | Strobe: pull SDA low for START |
| stop_pt | output | 1 | Strobe: release SDA for STOP |

## Verification
The hardest situations to reach from the ports are a stall that begins in exactly the cycle SCL is released, and a hold that is entered only at the boundary after a byte. To reach the stall, the bench models the line as a wired-AND of the block's drive and an external puller, and pulls the line down in the cycle of release for a counted number of cycles. It also pulls the line down during the low half, where the pull must have no effect. For hold, the bench first runs a whole period with `last_bit` at 0 to show that `hold_req` alone is ignored. It then raises `last_bit` in mid-period and releases the hold a known number of cycles later. Every strobe and line edge is scored against an expected cycle number.

// File: rtl/i2c_sclgen_pkg.sv
`timescale 1ns/1ps
package i2c_sclgen_pkg;

    localparam int STEPS     = 22;
    localparam int HALF      = STEPS / 2;
    localparam int MID       = 5;
    localparam int PH_W      = $clog2(STEPS);

    typedef logic [PH_W-1:0] phase_t;

    localparam phase_t LAST_PH = phase_t'(STEPS - 1);
    localparam phase_t HIGH_PH = phase_t'(HALF);
    localparam phase_t CHG_PH  = phase_t'(MID);
    localparam phase_t SMP_PH  = phase_t'(HALF + MID);

    typedef enum logic [1:0] {
        COND_NONE  = 2'd0,
        COND_START = 2'd1,
        COND_STOP  = 2'd2
    } cond_e;

    typedef struct packed {
        logic chg;
        logic smp;
        logic start;
        logic stop;
    } strobe_t;

    function automatic logic phase_is_high(phase_t p);
        return p >= HIGH_PH;
    endfunction

endpackage

// File: rtl/sclgen_prescaler.sv
`timescale 1ns/1ps
module sclgen_prescaler #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         wrap
);

    logic [W-1:0] cnt_q;

    assign wrap = en && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    // R3
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= limit);

endmodule

// File: rtl/sclgen_phase.sv
`timescale 1ns/1ps
module sclgen_phase
    import i2c_sclgen_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    enable,
    input  logic    tick,
    input  logic    scl_in,
    input  logic    hold_req,
    input  logic    last_bit,
    input  cond_e   cond,
    output logic    held,
    output logic    stall,
    output logic    period_end,
    output logic    resume,
    output logic    scl_low,
    output strobe_t strb
);

    phase_t phase_q;
    logic   held_q;

    assign held       = held_q;
    assign stall      = enable && !held_q && phase_is_high(phase_q) && !scl_in;
    assign period_end = tick && (phase_q == LAST_PH);
    assign resume     = held_q && !hold_req;
    assign scl_low    = enable && !phase_is_high(phase_q);

    always_comb begin
        strb.chg   = tick && (phase_q == CHG_PH);
        strb.smp   = tick && (phase_q == SMP_PH);
        strb.start = strb.smp && (cond == COND_START);
        strb.stop  = strb.smp && (cond == COND_STOP);
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            phase_q <= '0;
            held_q  <= 1'b0;
        end else if (resume) begin
            held_q  <= 1'b0;
        end else if (period_end) begin
            phase_q <= '0;
            held_q  <= hold_req && last_bit;
        end else if (tick) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // R6
    stall_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(phase_q));

    // R7
    held_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (held_q && hold_req && enable) |=> (held_q && phase_q == '0));

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({strb.chg, strb.smp, period_end}));

    // R2
    low_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_low) |-> ($past(period_end) || !$past(enable)));

endmodule

// File: rtl/i2c_scl_gen.sv
`timescale 1ns/1ps
module i2c_scl_gen
    import i2c_sclgen_pkg::*;
#(
    parameter int A_W = 2,
    parameter int B_W = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           enable,
    input  logic [A_W-1:0] div_a,
    input  logic [B_W-1:0] div_b,
    input  logic           scl_in,
    input  logic           hold_req,
    input  logic           last_bit,
    input  logic [1:0]     cond,
    output logic           scl_low,
    output logic           sda_chg,
    output logic           sda_smp,
    output logic           start_pt,
    output logic           stop_pt
);

    logic [A_W-1:0] a_lat;
    logic [B_W-1:0] b_lat;
    logic           held, stall, period_end, resume;
    logic           run, tick_a, tick, reload, pre_clr;
    strobe_t        strb;

    assign run     = enable && !held && !stall;
    assign reload  = !enable || period_end || resume;
    assign pre_clr = !enable || resume;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_lat <= '0;
            b_lat <= '0;
        end else if (reload) begin
            a_lat <= div_a;
            b_lat <= div_b;
        end
    end

    sclgen_prescaler #(.W(A_W)) u_pre_a (
        .clk   (clk),
        .rst   (rst),
        .clr   (pre_clr),
        .en    (run),
        .limit (a_lat),
        .wrap  (tick_a)
    );

    sclgen_prescaler #(.W(B_W)) u_pre_b (
        .clk   (clk),
        .rst   (rst),
        .clr   (pre_clr),
        .en    (tick_a),
        .limit (b_lat),
        .wrap  (tick)
    );

    sclgen_phase u_phase (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .tick       (tick),
        .scl_in     (scl_in),
        .hold_req   (hold_req),
        .last_bit   (last_bit),
        .cond       (cond_e'(cond)),
        .held       (held),
        .stall      (stall),
        .period_end (period_end),
        .resume     (resume),
        .scl_low    (scl_low),
        .strb       (strb)
    );

    assign sda_chg  = strb.chg;
    assign sda_smp  = strb.smp;
    assign start_pt = strb.start;
    assign stop_pt  = strb.stop;

    // R8
    div_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && !period_end && !resume) |=> ($stable(a_lat) && $stable(b_lat)));

    // R9
    idle_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !tick);

    // R5
    cond_high_chk: assert property (@(posedge clk) disable iff (rst)
        (start_pt || stop_pt) |-> !scl_low);

endmodule

// File: tb/i2c_scl_gen_bench.sv
`timescale 1ns/1ps
module i2c_scl_gen_bench;

    localparam int EV_LOW = 0, EV_REL = 1, EV_CHG = 2, EV_SMP = 3, EV_START = 4, EV_STOP = 5;

    typedef struct {
        int    kind;
        int    cyc;
        string req;
    } exp_t;

    logic       clk = 1'b0, rst = 1'b1, enable = 1'b0;
    logic [1:0] div_a = '0;
    logic [5:0] div_b = '0;
    logic       ext_low = 1'b0, hold_req = 1'b0, last_bit = 1'b0;
    logic [1:0] cond = 2'd0;
    logic       scl_in;
    logic       scl_low, sda_chg, sda_smp, start_pt, stop_pt;

    assign scl_in = !scl_low && !ext_low;

    i2c_scl_gen u_i2c_scl_gen (
        .clk(clk), .rst(rst), .enable(enable), .div_a(div_a), .div_b(div_b),
        .scl_in(scl_in), .hold_req(hold_req), .last_bit(last_bit), .cond(cond),
        .scl_low(scl_low), .sda_chg(sda_chg), .sda_smp(sda_smp),
        .start_pt(start_pt), .stop_pt(stop_pt)
    );

    always #2.5 clk = ~clk;

    int   cyc = 0;
    int   checks = 0, fails = 0;
    bit   mon_on = 1'b0;
    logic prev_low = 1'b0;
    exp_t sb_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: pops expected events and compares kind and cycle
    always @(negedge clk) begin
        bit [5:0] ev;
        ev[EV_LOW]   = scl_low && !prev_low;
        ev[EV_REL]   = !scl_low && prev_low;
        ev[EV_CHG]   = sda_chg;
        ev[EV_SMP]   = sda_smp;
        ev[EV_START] = start_pt;
        ev[EV_STOP]  = stop_pt;
        if (!rst && mon_on) begin
            for (int k = 0; k < 6; k++) begin
                if (ev[k]) begin
                    if (sb_q.size() == 0) begin
                        check(1'b0, "R2", $sformatf("unexpected event kind %0d", k), cyc, -1);
                    end else begin
                        exp_t e;
                        e = sb_q.pop_front();
                        check(e.kind == k && e.cyc == cyc, e.req,
                              $sformatf("event kind %0d (expected kind %0d) cycle", k, e.kind),
                              cyc, e.cyc);
                    end
                end
            end
        end
        prev_low = scl_low;
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_cyc(int c);
        while (cyc < c) step();
    endtask

    task automatic push(int k, int c, string req);
        exp_t e;
        e.kind = k;
        e.cyc  = c;
        e.req  = req;
        sb_q.push_back(e);
    endtask

    task automatic push_period(int base, int u, int stretch, bit with_low, string req);
        if (with_low) push(EV_LOW, base, req);
        push(EV_CHG, base + 6*u - 1, "R4");
        push(EV_REL, base + 11*u, req);
        push(EV_SMP, base + 17*u - 1 + stretch, "R4");
        if (cond == 2'd1) push(EV_START, base + 17*u - 1 + stretch, "R5");
        if (cond == 2'd2) push(EV_STOP, base + 17*u - 1 + stretch, "R5");
    endtask

    task automatic start_run(output int n);
        step();
        enable = 1'b1;
        mon_on = 1'b1;
        n = cyc;
    endtask

    task automatic finish_run(int last, string req);
        wait_cyc(last + 2);
        check(sb_q.size() == 0, req, "events still pending", sb_q.size(), 0);
        sb_q.delete();
        mon_on = 1'b0;
        enable = 1'b0;
        step();
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n, b2, n2;
        bit busy;
        repeat (4) step();
        check(scl_low == 1'b0, "R1", "scl_low in reset", scl_low, 0);
        rst = 1'b0;
        repeat (3) step();
        check({scl_low, sda_chg, sda_smp, start_pt, stop_pt} == 5'b0, "R1", "outputs after reset",
              {scl_low, sda_chg, sda_smp, start_pt, stop_pt}, 0);

        // R2 R4: fastest setting, three periods
        div_a = 2'd0; div_b = 6'd0; cond = 2'd0;
        step();
        start_run(n);
        for (int p = 0; p < 3; p++) push_period(n + 22*p, 1, 0, 1'b1, "R2");
        finish_run(n + 44 + 16, "R2");

        // R9: disabled in mid-period, nothing moves
        busy = 1'b0;
        for (int i = 0; i < 30; i++) begin
            busy |= scl_low | sda_chg | sda_smp | start_pt | stop_pt;
            step();
        end
        check(!busy, "R9", "activity while disabled", busy, 0);

        // R5 R9: START on every period, restart from step 0
        div_a = 2'd1; div_b = 6'd2; cond = 2'd1;
        step();
        start_run(n);
        push_period(n, 6, 0, 1'b1, "R9");
        push_period(n + 132, 6, 0, 1'b1, "R2");
        finish_run(n + 132 + 101, "R5");

        // R3 R5: widest divisors, STOP
        div_a = 2'd3; div_b = 6'd63; cond = 2'd2;
        step();
        start_run(n);
        push_period(n, 256, 0, 1'b1, "R3");
        push(EV_LOW, n + 5632, "R3");
        wait_cyc(n + 5632 + 1);
        check(sb_q.size() == 0, "R3", "events still pending", sb_q.size(), 0);
        sb_q.delete();
        mon_on = 1'b0;
        enable = 1'b0;
        repeat (2) step();

        // R6: stretch in high half, then pull during low half (ignored)
        div_a = 2'd0; div_b = 6'd1; cond = 2'd0;
        step();
        start_run(n);
        push_period(n, 2, 7, 1'b1, "R6");
        push_period(n + 51, 2, 0, 1'b1, "R6");
        wait_cyc(n + 22);
        ext_low = 1'b1;
        wait_cyc(n + 29);
        ext_low = 1'b0;
        wait_cyc(n + 53);
        ext_low = 1'b1;
        wait_cyc(n + 57);
        ext_low = 1'b0;
        finish_run(n + 51 + 33, "R6");

        // R7: hold ignored without last_bit, then honoured
        div_a = 2'd0; div_b = 6'd0; cond = 2'd0;
        hold_req = 1'b1; last_bit = 1'b0;
        step();
        start_run(n);
        b2 = n + 44;
        n2 = b2 + 11;
        push_period(n, 1, 0, 1'b1, "R7");
        push_period(n + 22, 1, 0, 1'b1, "R7");
        push(EV_LOW, b2, "R7");
        push_period(n2, 1, 0, 1'b0, "R7");
        wait_cyc(n + 25);
        last_bit = 1'b1;
        wait_cyc(b2 + 5);
        check(scl_low == 1'b1, "R7", "scl_low while held", scl_low, 1);
        wait_cyc(b2 + 10);
        hold_req = 1'b0;
        last_bit = 1'b0;
        finish_run(n2 + 16, "R7");

        // R8: divisor change in mid-period applies at next boundary
        div_a = 2'd0; div_b = 6'd1;
        step();
        start_run(n);
        push_period(n, 2, 0, 1'b1, "R8");
        push_period(n + 44, 4, 0, 1'b1, "R8");
        wait_cyc(n + 5);
        div_a = 2'd1;
        finish_run(n + 44 + 67, "R8");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule